// File: doc/BRIEF.md
# Reset, Standby and Clock-Enable Sequencer

This control unit sits in front of a still-image codec core. It watches four raw control inputs: the core reset request, the clock enable, the standby request and the freeze request. From them it decides when the core may be used. A reset request only counts when it is held long enough while the clock is enabled. Raising the clock enable starts a long settling countdown that stands in for the on-chip PLL.

Leaving standby opens a short guard interval before register access is granted. The unit grants host register access only in its ready state. It keeps the end indication and the compression-mode flag. It also raises a sticky violation flag whenever the host touches the registers at a forbidden moment, or enters standby before the end indication.

A freeze request parks the sequencer, holds its state and floats the data buses. Releasing the freeze resumes from the parked state. The unit also tri-states the control outputs when the test float request coincides with reset.

Top module: `codec_power_seq`

## Requirements
- R1: A reset takes effect (`state_o` becomes RESET, code 0) at the edge where `core_reset_i` and `clk_en_i` have both been sampled high on RESET_MIN (default 4) consecutive edges. A shorter pulse, or one with `clk_en_i` low, changes nothing.
- R2: When the reset takes effect, `viol_o` clears and `end_o`, `comp_mode_o` and `stop_o` go high. The state stays RESET while `core_reset_i` is high and moves to SETTLE (code 1) on the first edge that samples it low.
- R3: The clock counts as settled after SETTLE_CYC (default 5000) consecutive edges that sample `clk_en_i` high. A low sample restarts the count. From STANDBY (2), GUARD (3) or READY (4), a not-settled clock sends the state to SETTLE. SETTLE leaves only when the clock is settled: to STANDBY if `standby_i` is high, otherwise to GUARD.
- R4: The state reaches READY only after GUARD_CYC (default 4) consecutive edges that sample `standby_i` low with the clock settled. This count includes the edge that entered GUARD. A high `standby_i` in GUARD returns the state to STANDBY. From STANDBY, a low sample enters GUARD.
- R5: `ready_o` and `access_ok_o` are high exactly in READY, and `stop_o` is their inverse. A write accepted in READY (`reg_access_i` and `reg_write_i` both high) clears `end_o` and loads `comp_mode_o` from `mode_sel_i`.
- R6: `reg_access_i` sampled high outside READY sets `viol_o`, which stays set until `viol_clr_i` is sampled high. If a set and a clear fall on the same edge, the set wins.
- R7: `standby_i` high in READY moves the state to STANDBY. If `end_o` is low at that edge, `viol_o` is also set. `end_evt_i` sets `end_o` in every state except FROZEN, and it overrides a write clearing `end_o` on the same edge.
- R8: `freeze_i` sampled high in SETTLE, STANDBY, GUARD or READY moves the state to FROZEN (code 5) and raises `bus_float_o`. While frozen, `end_o`, `comp_mode_o` and the guard count hold. The first edge that samples `freeze_i` low returns the state to the one it was frozen from.
- R9: A qualified reset (R1) overrides freeze and takes effect from any state, including FROZEN. Freeze is not honoured in RESET.
- R10: `ctrl_hiz_o` is high exactly while `hiz_i` and `core_reset_i` are both high. It follows them combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| core_reset_i | input | 1 | Core reset request, needs qualification |
| clk_en_i | input | 1 | Clock enable; starts settling |
| standby_i | input | 1 | Standby request |
| freeze_i | input | 1 | Freeze request |
| hiz_i | input | 1 | Test float request |
| reg_access_i | input | 1 | Host register access attempt |
| reg_write_i | input | 1 | Attempt is a write |
| mode_sel_i | input | 1 | Compression mode loaded on accepted write |
| end_evt_i | input | 1 | Core reports end of process |
| viol_clr_i | input | 1 | Clears the violation flag |
| state_o | output | 3 | State code: 0 RESET, 1 SETTLE, 2 STANDBY, 3 GUARD, 4 READY, 5 FROZEN |
| ready_o | output | 1 | Core ready |
| access_ok_o | output | 1 | Host register access allowed |
| end_o | output | 1 | End indication |
| stop_o | output | 1 | Not ready to take data |
| comp_mode_o | output | 1 | Compression mode |
| bus_float_o | output | 1 | Data buses floating (frozen) |
| ctrl_hiz_o | output | 1 | Control outputs tri-stated |
| viol_o | output | 1 | Sticky access-rule violation |

## Verification
Two things can land on the same edge: the sticky violation flag can be set by a forbidden access or an early standby while `viol_clr_i` asks for it to be cleared, and a qualified reset can coincide with a freeze request. Directed sequences drive both pairs on one edge. The random phase then mixes clears, accesses, freezes and short and long reset pulses densely enough to repeat those collisions. Each edge is judged against a bench model that applies the priorities in the requirements: reset over everything, and a set over a clear.

// File: rtl/codec_power_pkg.sv
package codec_power_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_STANDBY = 3'd2,
    ST_GUARD   = 3'd3,
    ST_READY   = 3'd4,
    ST_FROZEN  = 3'd5
  } cps_state_e;
endpackage

// File: rtl/cps_width_filter.sv
module cps_width_filter #(
  parameter int MIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  logic [CW-1:0] cnt_q;
  logic          live;

  assign live  = req_i && en_i;
  assign hit_o = live && (cnt_q == CW'(MIN_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!live)                  cnt_q <= '0;
    else if (cnt_q != CW'(MIN_CYC))  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cps_settle_timer.sv
module cps_settle_timer #(
  parameter int SETTLE_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic settled_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  logic [SW-1:0] cnt_q;

  assign settled_o = (cnt_q == SW'(SETTLE_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (!settled_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import codec_power_pkg::*;
#(
  parameter int GUARD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       settled_i,
  input  logic       core_reset_i,
  input  logic       standby_i,
  input  logic       freeze_i,
  input  logic       reg_access_i,
  input  logic       reg_write_i,
  input  logic       mode_sel_i,
  input  logic       end_evt_i,
  input  logic       viol_clr_i,
  output cps_state_e state_o,
  output logic       end_o,
  output logic       comp_o,
  output logic       viol_o
);
  localparam int GW = $clog2(GUARD_CYC + 1);

  cps_state_e    st_q, st_d, ret_q, ret_d;
  logic [GW-1:0] g_q, g_d;
  logic          end_q, end_d, comp_q, comp_d, viol_q, viol_d;
  logic          bad_sb, wr_ok;

  assign wr_ok = (st_q == ST_READY) && reg_access_i && reg_write_i;

  always_comb begin
    st_d   = st_q;
    ret_d  = ret_q;
    g_d    = g_q;
    end_d  = end_q;
    comp_d = comp_q;
    viol_d = viol_q;
    bad_sb = 1'b0;
    if (hit_i) begin
      st_d   = ST_RESET;
      end_d  = 1'b1;
      comp_d = 1'b1;
      viol_d = 1'b0;
      g_d    = '0;
    end else begin
      case (st_q)
        ST_RESET:  if (!core_reset_i) st_d = ST_SETTLE;
        ST_FROZEN: if (!freeze_i) st_d = ret_q;
        default: begin
          if (freeze_i) begin
            ret_d = st_q;
            st_d  = ST_FROZEN;
          end else if (st_q == ST_SETTLE) begin
            if (settled_i) begin
              if (standby_i) st_d = ST_STANDBY;
              else begin
                st_d = ST_GUARD;
                g_d  = GW'(1);
              end
            end
          end else if (!settled_i) begin
            st_d = ST_SETTLE;
          end else if (st_q == ST_STANDBY) begin
            if (!standby_i) begin
              st_d = ST_GUARD;
              g_d  = GW'(1);
            end
          end else if (st_q == ST_GUARD) begin
            if (standby_i)                   st_d = ST_STANDBY;
            else if (g_q == GW'(GUARD_CYC - 1)) st_d = ST_READY;
            else                              g_d  = g_q + 1'b1;
          end else if (standby_i) begin
            st_d   = ST_STANDBY;
            bad_sb = !end_q;
          end
        end
      endcase
      if (wr_ok) begin
        end_d  = 1'b0;
        comp_d = mode_sel_i;
      end
      if (end_evt_i && st_q != ST_FROZEN) end_d = 1'b1;
      // set beats clear
      if ((reg_access_i && st_q != ST_READY) || bad_sb) viol_d = 1'b1;
      else if (viol_clr_i)                               viol_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RESET;
      ret_q  <= ST_SETTLE;
      g_q    <= '0;
      end_q  <= 1'b1;
      comp_q <= 1'b1;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ret_q  <= ret_d;
      g_q    <= g_d;
      end_q  <= end_d;
      comp_q <= comp_d;
      viol_q <= viol_d;
    end
  end

  assign state_o = st_q;
  assign end_o   = end_q;
  assign comp_o  = comp_q;
  assign viol_o  = viol_q;
endmodule

// File: rtl/codec_power_seq.sv
module codec_power_seq
  import codec_power_pkg::*;
#(
  parameter int RESET_MIN  = 4,
  parameter int SETTLE_CYC = 5000,
  parameter int GUARD_CYC  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       core_reset_i,
  input  logic       clk_en_i,
  input  logic       standby_i,
  input  logic       freeze_i,
  input  logic       hiz_i,
  input  logic       reg_access_i,
  input  logic       reg_write_i,
  input  logic       mode_sel_i,
  input  logic       end_evt_i,
  input  logic       viol_clr_i,
  output logic [2:0] state_o,
  output logic       ready_o,
  output logic       access_ok_o,
  output logic       end_o,
  output logic       stop_o,
  output logic       comp_mode_o,
  output logic       bus_float_o,
  output logic       ctrl_hiz_o,
  output logic       viol_o
);
  logic       hit, settled;
  cps_state_e st;

  cps_width_filter #(.MIN_CYC(RESET_MIN)) i_rst_filt (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(core_reset_i), .en_i(clk_en_i), .hit_o(hit)
  );

  cps_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(clk_en_i), .settled_o(settled)
  );

  cps_fsm #(.GUARD_CYC(GUARD_CYC)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .settled_i   (settled),
    .core_reset_i(core_reset_i),
    .standby_i   (standby_i),
    .freeze_i    (freeze_i),
    .reg_access_i(reg_access_i),
    .reg_write_i (reg_write_i),
    .mode_sel_i  (mode_sel_i),
    .end_evt_i   (end_evt_i),
    .viol_clr_i  (viol_clr_i),
    .state_o     (st),
    .end_o       (end_o),
    .comp_o      (comp_mode_o),
    .viol_o      (viol_o)
  );

  assign state_o     = st;
  assign ready_o     = (st == ST_READY);
  assign access_ok_o = ready_o;
  assign stop_o      = !ready_o;
  assign bus_float_o = (st == ST_FROZEN);
  assign ctrl_hiz_o  = hiz_i && core_reset_i;
endmodule

// File: rtl/codec_power_seq_chk.sv
module codec_power_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_reset_i,
  input logic       standby_i,
  input logic       freeze_i,
  input logic       viol_clr_i,
  input logic [2:0] state_o,
  input logic       end_o,
  input logic       stop_o,
  input logic       comp_mode_o,
  input logic       bus_float_o,
  input logic       viol_o
);
  // R2
  reset_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |-> (end_o && stop_o && comp_mode_o));

  // R2
  reset_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && !core_reset_i) |=> (state_o == 3'd1));

  // R4
  guard_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && standby_i && !core_reset_i && !freeze_i)
      |=> (state_o == 3'd2 || state_o == 3'd1));

  // R6
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !viol_clr_i && !core_reset_i) |=> viol_o);

  // R8
  freeze_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !core_reset_i && state_o != 3'd0 && state_o != 3'd5) |=> bus_float_o);

  // R8
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_float_o && $past(bus_float_o)) |-> ($stable(end_o) && $stable(comp_mode_o)));
endmodule

bind codec_power_seq codec_power_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .core_reset_i(core_reset_i),
  .standby_i   (standby_i),
  .freeze_i    (freeze_i),
  .viol_clr_i  (viol_clr_i),
  .state_o     (state_o),
  .end_o       (end_o),
  .stop_o      (stop_o),
  .comp_mode_o (comp_mode_o),
  .bus_float_o (bus_float_o),
  .viol_o      (viol_o)
);

// File: tb/test_codec_power_seq.sv
module test_codec_power_seq;
  localparam int RMIN = 4;
  localparam int SCYC = 5000;
  localparam int GCYC = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic core_reset_i = 0, clk_en_i = 1, standby_i = 0, freeze_i = 0, hiz_i = 0;
  logic reg_access_i = 0, reg_write_i = 0, mode_sel_i = 0, end_evt_i = 0, viol_clr_i = 0;
  logic [2:0] state_o;
  logic ready_o, access_ok_o, end_o, stop_o, comp_mode_o, bus_float_o, ctrl_hiz_o, viol_o;

  always #2 clk_i = ~clk_i;

  codec_power_seq #(.RESET_MIN(RMIN), .SETTLE_CYC(SCYC), .GUARD_CYC(GCYC)) i_codec_power_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .core_reset_i(core_reset_i), .clk_en_i(clk_en_i),
    .standby_i(standby_i), .freeze_i(freeze_i), .hiz_i(hiz_i), .reg_access_i(reg_access_i),
    .reg_write_i(reg_write_i), .mode_sel_i(mode_sel_i), .end_evt_i(end_evt_i),
    .viol_clr_i(viol_clr_i), .state_o(state_o), .ready_o(ready_o), .access_ok_o(access_ok_o),
    .end_o(end_o), .stop_o(stop_o), .comp_mode_o(comp_mode_o), .bus_float_o(bus_float_o),
    .ctrl_hiz_o(ctrl_hiz_o), .viol_o(viol_o)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  // reference model
  int m_st = 0, m_ret = 1, m_g = 0, m_rc = 0, m_sc = 0;
  bit m_end = 1, m_comp = 1, m_viol = 0;

  function automatic int sat_inc(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  task automatic model_step();
    bit hit, settled, bad, setv, wr;
    int st;
    hit     = core_reset_i && clk_en_i && (m_rc == RMIN - 1);
    settled = (m_sc == SCYC);
    st      = m_st;
    bad     = 0;
    wr      = (st == 4) && reg_access_i && reg_write_i;
    if (hit) begin
      m_st = 0; m_end = 1; m_comp = 1; m_viol = 0; m_g = 0;
    end else begin
      if (st == 0) begin
        if (!core_reset_i) m_st = 1;
      end else if (st == 5) begin
        if (!freeze_i) m_st = m_ret;
      end else if (freeze_i) begin
        m_ret = st; m_st = 5;
      end else if (st == 1) begin
        if (settled) begin
          if (standby_i) m_st = 2; else begin m_st = 3; m_g = 1; end
        end
      end else if (!settled) m_st = 1;
      else if (st == 2) begin
        if (!standby_i) begin m_st = 3; m_g = 1; end
      end else if (st == 3) begin
        if (standby_i) m_st = 2;
        else if (m_g == GCYC - 1) m_st = 4;
        else m_g = m_g + 1;
      end else if (standby_i) begin
        m_st = 2; bad = !m_end;
      end
      if (wr) begin m_end = 0; m_comp = mode_sel_i; end
      if (end_evt_i && st != 5) m_end = 1;
      setv = (reg_access_i && st != 4) || bad;
      if (setv) m_viol = 1; else if (viol_clr_i) m_viol = 0;
    end
    m_rc = (core_reset_i && clk_en_i) ? sat_inc(m_rc, RMIN) : 0;
    m_sc = clk_en_i ? sat_inc(m_sc, SCYC) : 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk("R1/R3/R4 state_o", state_o, m_st);
    chk("R5 ready_o", ready_o, m_st == 4);
    chk("R5 access_ok_o", access_ok_o, m_st == 4);
    chk("R5 stop_o", stop_o, m_st != 4);
    chk("R7 end_o", end_o, m_end);
    chk("R2 comp_mode_o", comp_mode_o, m_comp);
    chk("R6 viol_o", viol_o, m_viol);
    chk("R8 bus_float_o", bus_float_o, m_st == 5);
    chk("R10 ctrl_hiz_o", ctrl_hiz_o, hiz_i && core_reset_i);
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    cycles++;
    @(negedge clk_i);
    compare();
  endtask

  task automatic quiet();
    core_reset_i = 0; standby_i = 0; freeze_i = 0; reg_access_i = 0;
    reg_write_i = 0; end_evt_i = 0; viol_clr_i = 0; hiz_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", cycles);
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0051));
    repeat (3) @(negedge clk_i);
    compare();  // R2 reset state
    rst_ni = 1;
    // R3 R4: count edges to ready
    n = 0;
    while (!ready_o && n < 6000) begin cyc(); n++; end
    chk("R3 R4 edges to ready", n, SCYC + GCYC);
    // R5 write clears end, loads mode
    reg_access_i = 1; reg_write_i = 1; mode_sel_i = 0; cyc(); quiet();
    chk("R5 end cleared", end_o, 0);
    // R7 early standby -> violation
    standby_i = 1; cyc();
    chk("R7 early standby viol", viol_o, 1);
    standby_i = 0; repeat (GCYC + 1) cyc();
    // R6 set and clear same edge
    viol_clr_i = 1; cyc(); quiet();
    chk("R6 cleared", viol_o, 0);
    standby_i = 1; cyc(); reg_access_i = 1; viol_clr_i = 1; cyc(); quiet();
    chk("R6 set wins over clear", viol_o, 1);
    standby_i = 0; repeat (GCYC) cyc();
    // R1 short pulse ignored
    core_reset_i = 1; repeat (RMIN - 1) cyc(); core_reset_i = 0; cyc();
    chk("R1 short pulse ignored", state_o, 4);
    // R1 pulse with clock disabled ignored (also drops settle, R3)
    clk_en_i = 0; core_reset_i = 1; repeat (RMIN + 2) cyc(); core_reset_i = 0; cyc();
    chk("R1 unqualified reset", state_o, 1);
    clk_en_i = 1;
    // R8 freeze in settle, then R9 reset during freeze
    freeze_i = 1; cyc(); chk("R8 frozen", bus_float_o, 1);
    core_reset_i = 1; hiz_i = 1; repeat (RMIN) cyc();
    chk("R9 reset beats freeze", state_o, 0);
    chk("R10 hiz", ctrl_hiz_o, 1);
    quiet(); cyc();
    // random phase
    for (int i = 0; i < 60000; i++) begin
      automatic int r = $urandom_range(0, 999);
      if (core_reset_i) core_reset_i = ($urandom_range(0, 5) != 0);
      else core_reset_i = (r < 3);
      if (!clk_en_i) clk_en_i = ($urandom_range(0, 9) == 0);
      else if (r == 999) clk_en_i = 0;
      if ($urandom_range(0, 39) == 0) standby_i = !standby_i;
      if (freeze_i) freeze_i = ($urandom_range(0, 2) != 0);
      else freeze_i = ($urandom_range(0, 99) == 0);
      hiz_i        = $urandom_range(0, 1);
      reg_access_i = ($urandom_range(0, 9) == 0);
      reg_write_i  = $urandom_range(0, 1);
      mode_sel_i   = $urandom_range(0, 1);
      end_evt_i    = ($urandom_range(0, 149) == 0);
      viol_clr_i   = ($urandom_range(0, 19) == 0);
      cyc();
    end
    finish_run();
  end
endmodule